// File: doc/BRIEF.md
# Up-Mode Interval Timer with Split Interrupt Lines

This block is a peripheral timer built around a 16-bit counter fed from the system clock through a power-of-two divider. In up mode the counter runs from zero to the value held in compare register 0, then returns to zero, so a compare value of N-1 gives a period of N divided ticks. Each of several compare channels raises its own flag when the counter reaches that channel's compare value. A separate wrap flag is raised when the counter returns to zero.

Interrupts leave the block on two lines. The dedicated line serves only channel 0. Its flag clears by itself when the processor acknowledges that line. The shared line combines the other compare channels with the wrap event. Each source is gated by its own enable. Flags on the shared line stay pending until software clears them. A source code reports which enabled pending source on the shared line ranks highest.

Software reaches the block through a single-cycle register write port and a combinational read port. Writing the control register can stop the counter, select the divider, enable the wrap interrupt, and issue a one-shot clear of the counter and the divider.

Top module: `tick_timer`

## Requirements
- R1: In up mode the counter advances by one per divided tick and, when it equals compare register 0 (address 2), the next tick returns it to 0. Compare value N-1 gives a period of N ticks.
- R2: Divider select is control bits [3:2]. Value s divides the clock by 2^s, so s=2 gives one count every 4 clock cycles.
- R3: The `irq_ch0` output is high exactly while channel 0's flag (bit 1 of address 3) and its enable (bit 0 of address 3) are both set.
- R4: The wrap enable (control bit 4) gates only the wrap interrupt. Writing it to either value leaves `irq_ch0` unchanged.
- R5: The wrap flag (control bit 5) is set on the tick that returns the counter from the compare 0 value to 0, which is one tick after the counter reads the compare 0 value.
- R6: `irq_shared` is the OR of each enabled pending source among channels 1 and above and the wrap flag. `src_code` gives k for channel k (lower k ranks higher), gives the channel count (3 by default) for the wrap flag, and gives 0 when nothing is pending.
- R7: A pulse on `ack_ch0` clears channel 0's flag.
- R8: `ack_ch0` never clears a flag on the shared line. Those flags and `irq_shared` stay set until software writes the flag bit to 0.
- R9: Software may write any flag bit. If a hardware set and a software clear or acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R10: Mode field (control bits [1:0]) value 1 runs the counter and any other value stops it. Stopping holds the count and does not reset it.
- R11: Writing 1 to control bit 6 (self-clearing) resets both the counter and the divider. With divide-by-4, the first count after the clear arrives 4 cycles after the clearing write.
- R12: Channel k's flag (bit 1 of address 3+2k) is set on the tick at which the counter takes the value in compare register k (address 2+2k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| ack_ch0 | input | 1 | Acknowledge for the channel 0 line |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_shared | output | 1 | Shared interrupt for channels 1 and above and the wrap event |
| src_code | output | 2 | Highest-priority pending source on the shared line, 0 if none |

## Verification
A counter that has gone astray shows up on the count readout within one divided tick. It either skips past the compare 0 value or misses the return to zero, so the period and the time of the wrap flag both move away from what is expected. Flag-logic faults appear one cycle after the offending edge, as an interrupt line that stays high after an acknowledge, a shared flag that drops without a software write, or a flag that is lost when a set and a clear collide. Priority faults are visible at once on `src_code`. They are exercised by random combinations of flags and enables.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      RUN_STOP = 2'd0,
      RUN_UP   = 2'd1
   } run_mode_e;

   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_CNT  = 1;

   localparam int unsigned CC_IE_BIT   = 0;
   localparam int unsigned CC_FLAG_BIT = 1;

   function automatic int unsigned cmp_addr(input int unsigned k);
      return 2 + 2 * k;
   endfunction

   function automatic int unsigned cctl_addr(input int unsigned k);
      return 3 + 2 * k;
   endfunction

   function automatic int unsigned src_addr(input int unsigned n_ch);
      return 2 + 2 * n_ch;
   endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] sel,
   output logic             tick
);
   localparam int PW = (1 << DIV_W) - 1;

   logic [PW-1:0] presc_q;
   logic [PW-1:0] lim;
   logic          at_lim;

   always_comb begin
      lim    = PW'((32'd1 << sel) - 32'd1);
      at_lim = (presc_q >= lim);
      tick   = run && at_lim;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
      end else if (clr) begin
         presc_q <= '0;
      end else if (run) begin
         if (at_lim) presc_q <= '0;
         else        presc_q <= presc_q + 1'b1;
      end
   end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             adv,
   output logic             wrap_evt
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   always_comb begin
      at_top   = (cnt_q >= top);
      adv      = tick && !clr;
      wrap_evt = adv && at_top;
      cnt_nxt  = at_top ? '0 : cnt_q + 1'b1;
      cnt      = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (adv)   cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/tt_flag_cell.sv
module tt_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic hw_clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (sw_wr)  flag <= sw_val;
      else if (hw_clr) flag <= 1'b0;
   end
endmodule

// File: rtl/tt_prio_enc.sv
module tt_prio_enc #(
   parameter int NSRC = 3,
   localparam int CODE_W = $clog2(NSRC + 1)
) (
   input  logic [NSRC-1:0]   req,
   output logic [CODE_W-1:0] code
);
   always_comb begin
      code = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req[i]) code = CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3,
   parameter int DIV_W  = 2,
   parameter int ADDR_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [CNT_W-1:0]            wdata,
   output logic [CNT_W-1:0]            rdata,
   input  logic                        ack_ch0,
   output logic                        irq_ch0,
   output logic                        irq_shared,
   output logic [$clog2(NUM_CH+1)-1:0] src_code
);
   localparam int MODE_LSB  = 0;
   localparam int DIV_LSB   = 2;
   localparam int WIE_BIT   = DIV_LSB + DIV_W;
   localparam int WFLAG_BIT = WIE_BIT + 1;
   localparam int CLR_BIT   = WIE_BIT + 2;
   localparam int SRC_W     = $clog2(NUM_CH + 1);
   localparam int NEED_A    = $clog2(src_addr(NUM_CH) + 1);

   if (NUM_CH < 2)          begin : g_bad_ch  $error("NUM_CH must be at least 2"); end
   if (CNT_W < CLR_BIT + 1) begin : g_bad_w   $error("CNT_W too narrow for control fields"); end
   if (ADDR_W < NEED_A)     begin : g_bad_a   $error("ADDR_W too narrow for register map"); end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_d $error("DIV_W must be 1 to 3"); end

   logic [1:0]       mode_q;
   logic [DIV_W-1:0] div_q;
   logic             wrap_ie_q;
   logic [NUM_CH-1:0] ie_q;
   logic [CNT_W-1:0] cmp_q [NUM_CH];
   logic [NUM_CH-1:0] ch_flag;
   logic             wrap_flag;

   logic             ctrl_wr, clr_pulse, run_en, tick;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             adv, wrap_evt;
   logic [NUM_CH-1:0] shared_req;

   assign ctrl_wr   = wr_en && (addr == ADDR_W'(ADDR_CTRL));
   assign clr_pulse = ctrl_wr && wdata[CLR_BIT];
   assign run_en    = (mode_q == RUN_UP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= RUN_STOP;
         div_q     <= '0;
         wrap_ie_q <= 1'b0;
      end else if (ctrl_wr) begin
         mode_q    <= wdata[MODE_LSB +: 2];
         div_q     <= wdata[DIV_LSB +: DIV_W];
         wrap_ie_q <= wdata[WIE_BIT];
      end
   end

   tt_prescaler #(.DIV_W(DIV_W)) i_presc (
      .clk(clk), .rst_n(rst_n), .run(run_en), .clr(clr_pulse),
      .sel(div_q), .tick(tick)
   );

   tt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_pulse),
      .top(cmp_q[0]), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
      .adv(adv), .wrap_evt(wrap_evt)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic cmp_wr, cctl_wr, ch_clr;
      assign cmp_wr  = wr_en && (addr == ADDR_W'(cmp_addr(k)));
      assign cctl_wr = wr_en && (addr == ADDR_W'(cctl_addr(k)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q[k] <= '0;
            ie_q[k]  <= 1'b0;
         end else begin
            if (cmp_wr)  cmp_q[k] <= wdata;
            if (cctl_wr) ie_q[k]  <= wdata[CC_IE_BIT];
         end
      end

      if (k == 0) begin : g_ack
         assign ch_clr = ack_ch0;
      end else begin : g_noack
         assign ch_clr = 1'b0;
      end

      tt_flag_cell i_flag (
         .clk(clk), .rst_n(rst_n),
         .hw_set(adv && (cnt_nxt == cmp_q[k])),
         .sw_wr(cctl_wr), .sw_val(wdata[CC_FLAG_BIT]),
         .hw_clr(ch_clr), .flag(ch_flag[k])
      );

      if (k > 0) begin : g_req
         assign shared_req[k-1] = ch_flag[k] && ie_q[k];
      end
   end

   tt_flag_cell i_wrap_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(wrap_evt),
      .sw_wr(ctrl_wr), .sw_val(wdata[WFLAG_BIT]),
      .hw_clr(1'b0), .flag(wrap_flag)
   );

   assign shared_req[NUM_CH-1] = wrap_flag && wrap_ie_q;

   tt_prio_enc #(.NSRC(NUM_CH)) i_prio (.req(shared_req), .code(src_code));

   assign irq_ch0    = ch_flag[0] && ie_q[0];
   assign irq_shared = |shared_req;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_CTRL)) begin
         rdata[MODE_LSB +: 2]     = mode_q;
         rdata[DIV_LSB +: DIV_W]  = div_q;
         rdata[WIE_BIT]           = wrap_ie_q;
         rdata[WFLAG_BIT]         = wrap_flag;
      end else if (addr == ADDR_W'(ADDR_CNT)) begin
         rdata = cnt_q;
      end else if (addr == ADDR_W'(src_addr(NUM_CH))) begin
         rdata[SRC_W-1:0] = src_code;
      end
      for (int k = 0; k < NUM_CH; k++) begin
         if (addr == ADDR_W'(cmp_addr(k))) rdata = cmp_q[k];
         if (addr == ADDR_W'(cctl_addr(k))) begin
            rdata = '0;
            rdata[CC_IE_BIT]   = ie_q[k];
            rdata[CC_FLAG_BIT] = ch_flag[k];
         end
      end
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4,
   parameter int SRC_W  = 2,
   parameter int CLR_BIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic              ack_ch0,
   input logic              irq_ch0,
   input logic              irq_shared,
   input logic [SRC_W-1:0]  src_code,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  top,
   input logic              adv,
   input logic              run,
   input logic              wrap_flag
);
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt < top) |=> (cnt == $past(cnt) + 1'b1));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt == top) |=> (cnt == '0 && wrap_flag));

   p_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_shared == (src_code != '0));

   p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ch0 && !adv && !wr_en) |=> !irq_ch0);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_shared && !wr_en) |=> irq_shared);

   p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(cnt));

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0 && wdata[CLR_BIT]) |=> (cnt == '0));
endmodule

bind tick_timer tick_timer_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .CLR_BIT(CLR_BIT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .ack_ch0(ack_ch0), .irq_ch0(irq_ch0), .irq_shared(irq_shared),
   .src_code(src_code), .cnt(cnt_q), .top(cmp_q[0]), .adv(adv),
   .run(run_en), .wrap_flag(wrap_flag)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
   localparam int A_CTRL = 0, A_CNT = 1, A_CMP0 = 2, A_CC0 = 3,
                  A_CMP1 = 4, A_CC1 = 5, A_CMP2 = 6, A_CC2 = 7, A_SRC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        ack_ch0 = 1'b0;
   logic        irq_ch0, irq_shared;
   logic [1:0]  src_code;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   tick_timer i_tick_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ack_ch0(ack_ch0), .irq_ch0(irq_ch0),
      .irq_shared(irq_shared), .src_code(src_code)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input int a, output int d);
      addr = 4'(a);
      #1;
      d = int'(rdata);
   endtask

   task automatic wr(input int a, input int d);
      addr  = 4'(a);
      wdata = 16'(d);
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      int c;
      for (int i = 0; i < 2000; i++) begin
         rd(A_CNT, c);
         if (c == v) return;
         step();
      end
      chk(1'b0, "wait_cnt timeout", c, v);
   endtask

   function automatic int exp_src(input bit f1, e1, f2, e2, fw, ew);
      if (f1 && e1) return 1;
      if (f2 && e2) return 2;
      if (fw && ew) return 3;
      return 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int v, prev, chg;
      void'($urandom(32'd1234));
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // reset state
      rd(A_CTRL, v); chk(v == 0, "reset CTRL", v, 0);
      rd(A_CNT, v);  chk(v == 0, "reset CNT", v, 0);
      chk(!irq_ch0 && !irq_shared, "reset irqs", int'(irq_ch0) + int'(irq_shared), 0);

      // R1: period with compare 0 = 4
      wr(A_CMP0, 4); wr(A_CMP1, 2); wr(A_CMP2, 3);
      wr(A_CC0, 1);
      wr(A_CTRL, 16'h0001);
      rd(A_CNT, prev);
      for (int i = 0; i < 12; i++) begin
         step();
         rd(A_CNT, v);
         chk(v == ((prev == 4) ? 0 : prev + 1), "R1 sequence", v, (prev == 4) ? 0 : prev + 1);
         prev = v;
      end

      // R5: wrap flag one tick after counter equals compare 0
      wait_cnt(1);
      wr(A_CTRL, 16'h0001);
      rd(A_CTRL, v); chk(v[5] == 1'b0, "R5 wrap flag cleared", v[5], 0);
      wait_cnt(4);
      rd(A_CTRL, v); chk(v[5] == 1'b0, "R5 no wrap at top", v[5], 0);
      step();
      rd(A_CNT, v);  chk(v == 0, "R5 count returns to 0", v, 0);
      rd(A_CTRL, v); chk(v[5] == 1'b1, "R5 wrap flag set", v[5], 1);

      // R7: ack clears channel 0 flag (no collision: cnt 0 -> 1)
      rd(A_CC0, v); chk(v == 3, "R3 ch0 flag and enable", v, 3);
      chk(irq_ch0, "R3 irq_ch0 high", irq_ch0, 1);
      ack_ch0 = 1'b1; step(); ack_ch0 = 1'b0;
      rd(A_CC0, v); chk(v == 1, "R7 ack clears flag", v, 1);
      chk(!irq_ch0, "R7 irq_ch0 low", irq_ch0, 0);

      // R9: set wins over software clear (channel 1) and over ack (channel 0)
      wait_cnt(0);
      wr(A_CC1, 0);
      rd(A_CC1, v); chk(v == 0, "R9 ch1 cleared before match", v, 0);
      wr(A_CC1, 0);
      rd(A_CC1, v); chk(v == 2, "R9 ch1 set beats clear", v, 2);
      wait_cnt(2);
      ack_ch0 = 1'b1; step(); ack_ch0 = 1'b0;
      rd(A_CC0, v); chk(v == 1, "R9 ch0 cleared by ack", v, 1);
      ack_ch0 = 1'b1; step(); ack_ch0 = 1'b0;
      rd(A_CC0, v); chk(v == 3, "R9 ch0 set beats ack", v, 3);

      // R12: channel 2 flag at compare 2 = 3
      wait_cnt(4);
      wr(A_CC2, 0);
      rd(A_CC2, v); chk(v == 0, "R12 ch2 clear", v, 0);
      step(); step();
      rd(A_CC2, v); chk(v == 0, "R12 ch2 before match", v, 0);
      step();
      rd(A_CNT, prev);
      rd(A_CC2, v); chk(v == 2 && prev == 3, "R12 ch2 set at match", v, 2);

      // R10: stop holds count
      wait_cnt(3);
      wr(A_CTRL, 16'h0000);
      rd(A_CNT, prev);
      repeat (6) step();
      rd(A_CNT, v); chk(v == prev, "R10 stop holds", v, prev);
      chk(v != 0, "R10 stop does not reset", v, prev);

      // R11: clear resets counter and divider (divide by 4)
      wr(A_CTRL, 16'h0049);
      rd(A_CNT, v); chk(v == 0, "R11 cleared", v, 0);
      step(); step(); step();
      rd(A_CNT, v); chk(v == 0, "R11 no count before 4 cycles", v, 0);
      step();
      rd(A_CNT, v); chk(v == 1, "R11 first count after 4 cycles", v, 1);

      // R2: divide-by-4 rate
      wr(A_CMP0, 1000);
      wr(A_CTRL, 16'h0049);
      rd(A_CNT, prev); chg = 0;
      for (int i = 0; i < 40; i++) begin
         step();
         rd(A_CNT, v);
         if (v != prev) chg++;
         prev = v;
      end
      chk(chg == 10, "R2 divide by 4 count rate", chg, 10);
      chk(prev == 10, "R2 count after 40 cycles", prev, 10);

      // R4 / R3: wrap enable is not a global enable
      wr(A_CTRL, 16'h0040);
      wr(A_CC1, 0); wr(A_CC2, 0);
      wr(A_CC0, 3);
      wr(A_CTRL, 16'h0010);
      chk(irq_ch0, "R4 irq_ch0 with wrap enable set", irq_ch0, 1);
      wr(A_CTRL, 16'h0000);
      chk(irq_ch0, "R4 irq_ch0 with wrap enable clear", irq_ch0, 1);
      wr(A_CC0, 2);
      chk(!irq_ch0, "R3 irq_ch0 gated by enable", irq_ch0, 0);
      rd(A_CC0, v); chk(v == 2, "R3 flag kept when disabled", v, 2);

      // R8: shared flags persist through ack_ch0
      wr(A_CC1, 3);
      chk(irq_shared, "R8 shared asserted", irq_shared, 1);
      ack_ch0 = 1'b1; repeat (5) step(); ack_ch0 = 1'b0;
      chk(irq_shared, "R8 shared held after ack", irq_shared, 1);
      rd(A_CC1, v); chk(v == 3, "R8 ch1 flag held", v, 3);
      wr(A_CC1, 1);
      chk(!irq_shared, "R8 cleared by software", irq_shared, 0);

      // R6: random priority patterns on the shared line
      for (int i = 0; i < 200; i++) begin
         bit f1, e1, f2, e2, fw, ew;
         int e;
         {f1, e1, f2, e2, fw, ew} = 6'($urandom());
         wr(A_CC1, {f1, e1});
         wr(A_CC2, {f2, e2});
         wr(A_CTRL, (int'(fw) << 5) | (int'(ew) << 4));
         e = exp_src(f1, e1, f2, e2, fw, ew);
         chk(int'(src_code) == e, "R6 source code", src_code, e);
         rd(A_SRC, v); chk(v == e, "R6 source readout", v, e);
         chk(irq_shared == (e != 0), "R6 shared line", irq_shared, e != 0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule